// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Stage

This block is a streaming correction stage for RGB video. Every 8-bit colour component is replaced by the value stored in a programmable curve. There is one curve per colour channel, so red, green and blue can each get a different gamma. Each stream beat carries four pixels. All twelve components of a beat are remapped in the same clock, which lets a 2160p60 stream pass at about 150 MHz.

Curves are loaded through a plain write port, one entry per cycle. Software may load curves while video is flowing. New entries collect in a staging copy, and that copy is committed to the working copy only when a frame-start beat enters the stage, so no frame is ever split between two curves.

A bypass input lets pixels through unchanged with the same latency. A synchronous clear input, pulsed between resolution changes, discards the beats in flight and leaves the curves alone. The commit control is a two-state machine:
- State `TBL_SYNCED` means the working copy matches the staging copy.
- State `TBL_DIRTY` means a write is waiting.
- Transition *stage-write* (`TBL_SYNCED` to `TBL_DIRTY`) happens on a write to a valid channel.
- Transition *frame-commit* (`TBL_DIRTY` to `TBL_SYNCED`) happens when a frame-start beat is accepted and no write arrives in that same cycle.
- Transition *commit-and-restage* (`TBL_DIRTY` to `TBL_DIRTY`) happens when a frame-start beat and a write arrive together.

Top module: `gamma_lut_stage`

## Requirements
- R1: While `rst_n` is low, and after it is released, `m_tvalid` is 0 and `s_tready` is 1 until a beat is offered.
- R2: Each output component equals the curve entry of its own channel at the index given by the input component. Pixel p of a beat occupies `tdata[24p+23:24p]`. Within a pixel, red is bits [7:0], green is bits [15:8] and blue is bits [23:16]. All four pixels are mapped in the same beat.
- R3: The three channels hold independent curves: writing one channel's curve changes no output component of the other two channels.
- R4: When `tbl_we` is 1, one entry is written per cycle: `tbl_data` goes to index `tbl_idx` of the curve picked by `tbl_chan` (0 red, 1 green, 2 blue). A write with `tbl_chan` = 3 is ignored.
- R5: A beat accepted on one rising edge appears on the output right after the next rising edge, provided the output is not stalled (two register stages).
- R6: `m_tuser` (frame start) and `m_tlast` (end of line) leave with the same beat they entered with.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, the output beat holds stable and `s_tready` drops once both stages are full. No beat is lost, duplicated or reordered.
- R8: `bypass` is sampled together with each accepted beat. A bypassed beat leaves bit-identical to its input, with the same latency.
- R9: Written entries reach the pixels from the next accepted beat that has `s_tuser` = 1. Beats without `s_tuser` keep the previous curves. A write in the same cycle that a frame-start beat is accepted waits for the following frame start.
- R10: `soft_clr` = 1 holds `s_tready` low and empties both stages, so `m_tvalid` is 0 after that edge. Curve contents and staged, uncommitted writes survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of in-flight beats |
| bypass | input | 1 | Pass pixels unchanged, sampled per beat |
| tbl_we | input | 1 | Curve entry write strobe |
| tbl_chan | input | 2 | Curve select: 0 red, 1 green, 2 blue, 3 none |
| tbl_idx | input | 8 | Curve entry index |
| tbl_data | input | 8 | Curve entry value |
| s_tdata | input | 96 | Input pixels, four per beat |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tuser | input | 1 | Input frame start |
| s_tlast | input | 1 | Input end of line |
| m_tdata | output | 96 | Output pixels |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Output frame start |
| m_tlast | output | 1 | Output end of line |

## Verification
The bench builds the block with its default four pixels per beat and 8-bit components. At that size a curve has only 256 entries, so the bench loads every index of every channel from arithmetic formulas and sweeps all 256 input values per channel in a single 64-beat frame. This small configuration also makes it practical to check curve changes at the entry level. It covers a rewrite in the middle of a frame, a write that lands on the same cycle as a frame start, and a staged write that is carried across a clear, all against a bench model that holds its own staging and working copies.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int NUM_COMP = 3;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2,
        CH_NONE  = 2'd3
    } chan_sel_e;

    typedef enum logic {
        TBL_SYNCED = 1'b0,
        TBL_DIRTY  = 1'b1
    } tbl_state_e;

endpackage

// File: rtl/gamma_commit_fsm.sv
module gamma_commit_fsm
    import gamma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic sof_fire,
    output logic commit
);

    tbl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TBL_SYNCED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TBL_SYNCED: if (wr_hit) state_d = TBL_DIRTY;
            TBL_DIRTY:  if (sof_fire) state_d = wr_hit ? TBL_DIRTY : TBL_SYNCED;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            TBL_SYNCED: commit = 1'b0;
            TBL_DIRTY:  commit = sof_fire;
        endcase
    end

endmodule

// File: rtl/gamma_chan_table.sv
module gamma_chan_table #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 8,
    parameter int NRD   = 4
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [VAL_W-1:0]           wdata,
    input  logic                       commit,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][VAL_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [VAL_W-1:0] staged  [DEPTH];
    logic [VAL_W-1:0] working [DEPTH];

    // Staging copy takes writes; working copy is replaced whole on commit.
    always_ff @(posedge clk) begin
        if (we)     staged[widx] <= wdata;
        if (commit) working      <= staged;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = working[rd_idx[r]];
    end

endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
    import gamma_pkg::*;
#(
    parameter int PIX_PER_BEAT = 4,
    parameter int COMP_W       = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   soft_clr,
    input  logic                                   bypass,
    input  logic                                   tbl_we,
    input  logic [1:0]                             tbl_chan,
    input  logic [COMP_W-1:0]                      tbl_idx,
    input  logic [COMP_W-1:0]                      tbl_data,
    input  logic [PIX_PER_BEAT*NUM_COMP*COMP_W-1:0] s_tdata,
    input  logic                                   s_tvalid,
    output logic                                   s_tready,
    input  logic                                   s_tuser,
    input  logic                                   s_tlast,
    output logic [PIX_PER_BEAT*NUM_COMP*COMP_W-1:0] m_tdata,
    output logic                                   m_tvalid,
    input  logic                                   m_tready,
    output logic                                   m_tuser,
    output logic                                   m_tlast
);

    localparam int PIX_W  = NUM_COMP * COMP_W;
    localparam int DATA_W = PIX_PER_BEAT * PIX_W;

    logic              adv, s_fire, sof_fire, wr_hit, tbl_commit;
    logic              a_valid, a_user, a_last, a_byp;
    logic [DATA_W-1:0] a_data;
    logic              b_valid, b_user, b_last;
    logic [DATA_W-1:0] b_data;
    logic [DATA_W-1:0] lut_out, b_next;

    // Both stages move together whenever the output slot is free.
    assign adv      = !b_valid || m_tready;
    assign s_tready = adv && !soft_clr;
    assign s_fire   = s_tvalid && s_tready;
    assign sof_fire = s_fire && s_tuser;
    assign wr_hit   = tbl_we && (tbl_chan != CH_NONE);

    gamma_commit_fsm u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .sof_fire (sof_fire),
        .commit   (tbl_commit)
    );

    for (genvar ch = 0; ch < NUM_COMP; ch++) begin : g_chan
        logic [PIX_PER_BEAT-1:0][COMP_W-1:0] idx_v;
        logic [PIX_PER_BEAT-1:0][COMP_W-1:0] val_v;

        for (genvar p = 0; p < PIX_PER_BEAT; p++) begin : g_pix
            assign idx_v[p] = a_data[p*PIX_W + ch*COMP_W +: COMP_W];
            assign lut_out[p*PIX_W + ch*COMP_W +: COMP_W] = val_v[p];
        end

        gamma_chan_table #(
            .IDX_W (COMP_W),
            .VAL_W (COMP_W),
            .NRD   (PIX_PER_BEAT)
        ) u_tbl (
            .clk     (clk),
            .we      (tbl_we && (tbl_chan == 2'(ch))),
            .widx    (tbl_idx),
            .wdata   (tbl_data),
            .commit  (tbl_commit),
            .rd_idx  (idx_v),
            .rd_data (val_v)
        );
    end

    assign b_next = a_byp ? a_data : lut_out;

    // Stage A: capture the accepted beat (commit lands on the same edge).
    always_ff @(posedge clk) begin
        if (!rst_n)        a_valid <= 1'b0;
        else if (soft_clr) a_valid <= 1'b0;
        else if (adv)      a_valid <= s_tvalid;
    end

    always_ff @(posedge clk) begin
        if (adv && s_tvalid) begin
            a_data <= s_tdata;
            a_user <= s_tuser;
            a_last <= s_tlast;
            a_byp  <= bypass;
        end
    end

    // Stage B: registered lookup result, presented on the output.
    always_ff @(posedge clk) begin
        if (!rst_n)        b_valid <= 1'b0;
        else if (soft_clr) b_valid <= 1'b0;
        else if (adv)      b_valid <= a_valid;
    end

    always_ff @(posedge clk) begin
        if (adv && a_valid) begin
            b_data <= b_next;
            b_user <= a_user;
            b_last <= a_last;
        end
    end

    assign m_tdata  = b_data;
    assign m_tvalid = b_valid;
    assign m_tuser  = b_user;
    assign m_tlast  = b_last;

endmodule

// File: rtl/gamma_lut_stage_chk.sv
module gamma_lut_stage_chk #(
    parameter int DATA_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clr,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              s_tuser,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic              m_tuser,
    input logic              m_tlast,
    input logic              tbl_commit
);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tuser) && $stable(m_tlast)));

    p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !m_tvalid);

    p_commit_on_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_commit |-> (s_tvalid && s_tready && s_tuser));

    p_two_stage_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        $rose(m_tvalid) |-> $past(s_tvalid && s_tready, 2));

endmodule

bind gamma_lut_stage gamma_lut_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .s_tvalid   (s_tvalid),
    .s_tready   (s_tready),
    .s_tuser    (s_tuser),
    .m_tdata    (m_tdata),
    .m_tvalid   (m_tvalid),
    .m_tready   (m_tready),
    .m_tuser    (m_tuser),
    .m_tlast    (m_tlast),
    .tbl_commit (tbl_commit)
);

// File: tb/gamma_lut_stage_tb_top.sv
module gamma_lut_stage_tb_top;

    localparam int DW = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clr = 1'b0;
    logic          bypass = 1'b0;
    logic          tbl_we = 1'b0;
    logic [1:0]    tbl_chan = 2'd0;
    logic [7:0]    tbl_idx = 8'd0;
    logic [7:0]    tbl_data = 8'd0;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          s_tuser = 1'b0;
    logic          s_tlast = 1'b0;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready;
    logic          m_tuser;
    logic          m_tlast;

    always #5 clk = ~clk;

    gamma_lut_stage dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .bypass(bypass),
        .tbl_we(tbl_we), .tbl_chan(tbl_chan), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    typedef struct {
        logic [DW-1:0] d;
        logic          u;
        logic          l;
        string         tag;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] staged_m  [3][256];
    logic [7:0] working_m [3][256];
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 0;
    int         bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] curve(input int k, input int c, input int x);
        if (k == 0) begin
            if (c == 0)      return 8'(255 - x);
            else if (c == 1) return 8'((x * x) >> 8);
            else             return 8'(x ^ 90);
        end
        return 8'(x * 3 + 7);
    endfunction

    function automatic logic [DW-1:0] model(input logic [DW-1:0] d, input bit byp);
        logic [DW-1:0] r;
        if (byp) return d;
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 3; c++)
                r[p*24 + c*8 +: 8] = working_m[c][d[p*24 + c*8 +: 8]];
        return r;
    endfunction

    // Downstream ready pattern: 0 always ready, 1 pseudo-random, 2 held low.
    initial begin
        m_tready = 1'b1;
        forever begin
            @(posedge clk); #1;
            case (bp_mode)
                0: m_tready = 1'b1;
                1: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    m_tready = lfsr[0] | lfsr[3];
                end
                default: m_tready = 1'b0;
            endcase
        end
    end

    // Output scoreboard (R2, R6, R7 ordering).
    always @(negedge clk) begin
        if (rst_n && m_tvalid && m_tready) begin
            exp_t e;
            if (expq.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R7 unexpected output beat act=%h exp=none", m_tdata);
            end else begin
                e = expq.pop_front();
                n_checks++;
                if (m_tdata !== e.d || m_tuser !== e.u || m_tlast !== e.l) begin
                    n_fail++;
                    $display("FAIL %s beat act=%h/%b/%b exp=%h/%b/%b",
                             e.tag, m_tdata, m_tuser, m_tlast, e.d, e.u, e.l);
                end
            end
        end
    end

    // All tasks start just after a rising edge.
    task automatic write_entry(input int ch, input int idx, input int val);
        tbl_we = 1'b1; tbl_chan = 2'(ch); tbl_idx = 8'(idx); tbl_data = 8'(val);
        @(posedge clk); #1;
        tbl_we = 1'b0;
        if (ch < 3) staged_m[ch][idx] = 8'(val);
    endtask

    task automatic load_curve(input int k, input int ch_first, input int ch_last);
        for (int c = ch_first; c <= ch_last; c++)
            for (int x = 0; x < 256; x++)
                write_entry(c, x, curve(k, c, x));
    endtask

    task automatic send_beat(input logic [DW-1:0] d, input bit u, input bit l,
                             input bit byp, input bit keep, input string tag,
                             input bit do_wr, input int wch, input int widx, input int wval);
        bit ok;
        exp_t e;
        s_tdata = d; s_tuser = u; s_tlast = l; bypass = byp; s_tvalid = 1'b1;
        if (do_wr) begin
            tbl_we = 1'b1; tbl_chan = 2'(wch); tbl_idx = 8'(widx); tbl_data = 8'(wval);
        end
        do begin
            @(negedge clk);
            ok = s_tready;
            if (!ok) @(posedge clk);
        end while (!ok);
        if (u) working_m = staged_m;
        if (do_wr && wch < 3) staged_m[wch][widx] = 8'(wval);
        if (keep) begin
            e.d = model(d, byp); e.u = u; e.l = l; e.tag = tag;
            expq.push_back(e);
        end
        @(posedge clk); #1;
        s_tvalid = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic send_frame(input int first, input int n, input int base,
                              input int byp_mode, input string tag);
        for (int b = first; b < first + n; b++) begin
            logic [DW-1:0] d;
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 3; c++)
                    d[p*24 + c*8 +: 8] = 8'(4*b + p + 85*c + base);
            send_beat(d, b == 0, (b % 8) == 7, byp_mode == 1 && (b % 2) == 1,
                      1'b1, tag, 1'b0, 0, 0, 0);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 5000 && expq.size() != 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        check(expq.size() == 0, "R7", "beats still owed", expq.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R1", "m_tvalid during reset", m_tvalid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R1", "m_tvalid after reset", m_tvalid, 0);
        check(s_tready == 1'b1, "R1", "s_tready after reset", s_tready, 1);
        @(posedge clk); #1;

        // R4 load, then R2/R6 full sweep of every index per channel.
        load_curve(0, 0, 2);
        send_frame(0, 64, 0, 0, "R2/R6 sweep");
        drain();

        // R5 latency with output free.
        send_beat({24'h0A0B0C, 24'h102030, 24'hFFFEFD, 24'h010203}, 1'b0, 1'b1,
                  1'b0, 1'b1, "R5", 1'b0, 0, 0, 0);
        @(negedge clk);
        check(m_tvalid == 1'b0, "R5", "valid one edge after accept", m_tvalid, 0);
        @(negedge clk);
        check(m_tvalid == 1'b1, "R5", "valid two edges after accept", m_tvalid, 1);
        drain();

        // R7 random backpressure.
        bp_mode = 1;
        send_frame(0, 64, 17, 0, "R7 backpressure");
        drain();
        bp_mode = 0;

        // R8 alternating bypass.
        send_frame(0, 32, 3, 1, "R8 bypass");
        drain();

        // R9 mid-frame rewrite of red, R3 other channels untouched.
        send_frame(0, 10, 40, 0, "R9 before write");
        load_curve(1, 0, 0);
        send_frame(10, 10, 40, 0, "R9 same frame old curve");
        send_frame(0, 64, 9, 0, "R3 red new, green/blue old");
        drain();

        // R4 writes to channel 3 are ignored.
        for (int x = 0; x < 256; x++) write_entry(3, x, 0);
        send_frame(0, 64, 5, 0, "R4 chan3 ignored");
        drain();

        // R9 write landing in the frame-start cycle waits one more frame.
        write_entry(0, 5, 8'h11);
        send_beat({24'h000707, 24'h000606, 24'h000606, 24'h000505}, 1'b1, 1'b0,
                  1'b0, 1'b1, "R9 same-cycle commit", 1'b1, 0, 6, 8'h22);
        send_beat({24'h000707, 24'h000606, 24'h000606, 24'h000505}, 1'b1, 1'b1,
                  1'b0, 1'b1, "R9 next frame", 1'b0, 0, 0, 0);
        drain();

        // R10 clear with beats in flight; staged write must survive.
        write_entry(1, 8'h40, 8'h99);
        bp_mode = 2;
        @(posedge clk); @(posedge clk); #1;
        send_beat({4{24'h123456}}, 1'b0, 1'b0, 1'b0, 1'b0, "R10", 1'b0, 0, 0, 0);
        send_beat({4{24'h654321}}, 1'b0, 1'b0, 1'b0, 1'b0, "R10", 1'b0, 0, 0, 0);
        @(negedge clk);
        check(s_tready == 1'b0, "R7", "s_tready with both stages full", s_tready, 0);
        check(m_tvalid == 1'b1, "R7", "stalled beat still offered", m_tvalid, 1);
        @(posedge clk); #1;
        soft_clr = 1'b1;
        @(negedge clk);
        check(s_tready == 1'b0, "R10", "s_tready during clear", s_tready, 0);
        @(posedge clk); #1;
        soft_clr = 1'b0;
        bp_mode = 0;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R10", "m_tvalid after clear", m_tvalid, 0);
        repeat (3) @(negedge clk);
        check(m_tvalid == 1'b0, "R10", "no stale beat emerges", m_tvalid, 0);
        @(posedge clk); #1;
        send_frame(0, 16, 235, 0, "R10 tables and staged write kept");
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule